// File: doc/BRIEF.md
# Data-Side Level-One Access Steering Unit

This unit sits on the data side of a level-one memory system and decides, for every load or store beat, which storage serves it. The candidates are a tightly coupled data RAM, a tightly coupled instruction RAM, the data cache, a cache line fill, or a plain level-two access. The choice follows a fixed priority. The instruction RAM is considered first. The data RAM is considered second. A data-cache hit comes next. The remaining cases go to fill or level two, depending on the cacheable attribute and the cache-enable bit. Write-through copies to level two are suppressed whenever a tightly coupled RAM takes the write.

To save power, the data RAM chip select is raised speculatively in the accept cycle only when the previous access was served by the data RAM. If the address then disagrees with that guess, the access is restarted and completes a fixed number of cycles late. An instruction-RAM access is never speculative. It is issued only after the hit is known, a fixed number of cycles after acceptance, and this applies to every beat of a multi-word transfer.

Requests use a valid/ready handshake, and the requester holds all request fields stable while ready is low. Reads served by either tightly coupled RAM or by the cache return data on `rsp_data`, together with a single-cycle `rsp_valid` pulse, one cycle after issue.

Top module: `dside_router`

## Requirements
- R1: An address inside the enabled instruction-RAM window is served by the instruction RAM (`itcm_cs`, plus `itcm_we` for writes). No data-RAM write, cache strobe, fill or level-two strobe is raised for it, whatever the data RAM and the cache report.
- R2: An address inside the data-RAM window and outside the instruction-RAM window is served by the data RAM. This holds even when `dc_hit` is high, and no `dc_rd` or `dc_wr` is raised.
- R3: A write to either tightly coupled RAM never raises `l2_wr`, even with `req_wthru` high. A read from either never raises `fill_req`, even when the access is cacheable and the cache is enabled.
- R4: When all three targets miss, a read raises `fill_req` if `req_cacheable` and `cache_en` are both high, and raises `l2_rd` otherwise. A write raises `l2_wr`.
- R5: On a cache-only hit, a read raises `dc_rd`. A write raises `dc_wr`, and raises `l2_wr` in the same cycle exactly when `req_wthru` is high.
- R6: After reset the predictor expects a miss. In the accept cycle of a request, `dtcm_cs` is high only if the previous completed access was served by the data RAM, or if this access is being issued to the data RAM.
- R7: When the data-RAM window test disagrees with the prediction (and the instruction RAM misses), `req_ready` stays low and the access is issued RESTART_CYC (default 2) cycles after the accept cycle. The prediction is corrected at that point.
- R8: An instruction-RAM access holds `req_ready` low and is issued ITCM_DLY (default 3) cycles after its accept cycle. Every beat of a back-to-back sequence is delayed the same way.
- R9: The window test is `base <= addr < base + 2**size_log2`, evaluated on a 33-bit sum. When a window's enable input is low, that window never hits.
- R10: `rsp_valid` pulses for one cycle, one cycle after a read is issued to a tightly coupled RAM or the cache. `rsp_data` then carries that source's read data. Writes, fills and level-two reads produce no pulse.
- R11: Every access strobe other than the speculative `dtcm_cs` is raised only in a cycle where both `req_valid` and `req_ready` are high. With no request, the only strobe raised is none at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completes this cycle |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_cacheable | input | 1 | Page is cacheable |
| req_wthru | input | 1 | Page is write-through |
| cache_en | input | 1 | Data cache enabled |
| dtcm_on | input | 1 | Data-RAM window enable |
| dtcm_base | input | AW | Data-RAM window base |
| dtcm_szlog | input | SW | Data-RAM window size, log2 bytes |
| itcm_on | input | 1 | Instruction-RAM window enable |
| itcm_base | input | AW | Instruction-RAM window base |
| itcm_szlog | input | SW | Instruction-RAM window size, log2 bytes |
| dc_hit | input | 1 | Cache tag hit for `req_addr` |
| mem_addr | output | AW | Address of the issued access |
| dtcm_cs | output | 1 | Data-RAM chip select |
| dtcm_we | output | 1 | Data-RAM write enable |
| itcm_cs | output | 1 | Instruction-RAM chip select |
| itcm_we | output | 1 | Instruction-RAM write enable |
| dc_rd | output | 1 | Cache read |
| dc_wr | output | 1 | Cache write |
| fill_req | output | 1 | Start line fill |
| l2_rd | output | 1 | Level-two read |
| l2_wr | output | 1 | Level-two write |
| dtcm_rdata | input | DW | Data-RAM read data |
| itcm_rdata | input | DW | Instruction-RAM read data |
| dc_rdata | input | DW | Cache read data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DW | Read data |

## Verification
The routing table is exercised with every mix of window hit, cache hit, write, cacheable, write-through and cache enable, including addresses inside both windows. These patterns separate the priority order from the attribute-driven fill and write-through choices. The window test is probed one byte below the base, at the base, at the last byte and one past the end, and again with each enable low, so that an off-by-one comparison or an ignored enable shows up as a wrong target. Alternating data-RAM and non-data-RAM sequences force mispredictions in both directions, while repeated data-RAM accesses show the zero-penalty predicted path. Back-to-back instruction-RAM beats show that the delay is paid per beat and not only once per transfer.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  // One-hot-ish strobe set chosen for an access
  typedef struct packed {
    logic dtcm;
    logic itcm;
    logic c_rd;
    logic c_wr;
    logic fill;
    logic l2_rd;
    logic l2_wr;
  } route_t;

  typedef enum logic [1:0] {
    SRC_DTCM = 2'd0,
    SRC_ITCM = 2'd1,
    SRC_DC   = 2'd2
  } rsp_src_e;

endpackage

// File: rtl/dsr_range.sv
module dsr_range #(
  parameter int AW = 32,
  parameter int SW = 6
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] szlog,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [AW:0] span;
  logic [AW:0] limit;

  always_comb begin
    span  = (AW+1)'(1) << szlog;
    limit = {1'b0, base} + span;
    hit   = en && (addr >= base) && ({1'b0, addr} < limit);
  end

endmodule

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
(
  input  logic   it_hit,
  input  logic   dt_hit,
  input  logic   dc_hit,
  input  logic   wr,
  input  logic   cacheable,
  input  logic   wthru,
  input  logic   cache_en,
  output route_t route
);

  always_comb begin
    route = '0;
    if (it_hit) begin
      route.itcm = 1'b1;
    end else if (dt_hit) begin
      route.dtcm = 1'b1;
    end else if (dc_hit) begin
      if (wr) begin
        route.c_wr  = 1'b1;
        route.l2_wr = wthru;
      end else begin
        route.c_rd = 1'b1;
      end
    end else if (wr) begin
      route.l2_wr = 1'b1;
    end else if (cacheable && cache_en) begin
      route.fill = 1'b1;
    end else begin
      route.l2_rd = 1'b1;
    end
  end

endmodule

// File: rtl/dsr_predict.sv
module dsr_predict (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic upd_hit,
  output logic pred
);

  logic pred_q;
  logic pred_n;

  always_comb begin
    pred_n = pred_q;
    if (upd) pred_n = upd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_q <= 1'b0;
    else        pred_q <= pred_n;
  end

  assign pred = pred_q;

endmodule

// File: rtl/dsr_seq.sv
module dsr_seq
  import dsr_pkg::*;
#(
  parameter int AW          = 32,
  parameter int RESTART_CYC = 2,
  parameter int ITCM_DLY    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  route_t        live_route,
  input  logic          live_it,
  input  logic          live_dt,
  input  logic          pred,
  output logic          req_ready,
  output logic          issue,
  output route_t        iss_route,
  output logic          iss_write,
  output logic [AW-1:0] iss_addr,
  output logic          upd,
  output logic          upd_hit,
  output logic          spec_dtcm
);

  localparam int MAXW = (RESTART_CYC > ITCM_DLY) ? RESTART_CYC : ITCM_DLY;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic {S_IDLE, S_STALL} st_e;

  st_e           st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  route_t        hold_route_q;
  logic          hold_wr_q;
  logic [AW-1:0] hold_addr_q;
  logic          cap;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    cap       = 1'b0;
    req_ready = 1'b0;
    issue     = 1'b0;
    upd       = 1'b0;
    upd_hit   = 1'b0;
    spec_dtcm = 1'b0;
    iss_route = hold_route_q;
    iss_write = hold_wr_q;
    iss_addr  = hold_addr_q;
    case (st_q)
      S_IDLE: begin
        iss_route = live_route;
        iss_write = req_write;
        iss_addr  = req_addr;
        req_ready = 1'b1;
        if (req_valid) begin
          spec_dtcm = pred;
          if (live_it) begin
            req_ready = 1'b0;
            cap       = 1'b1;
            st_n      = S_STALL;
            cnt_n     = CW'(ITCM_DLY - 1);
          end else if (live_dt != pred) begin
            req_ready = 1'b0;
            cap       = 1'b1;
            st_n      = S_STALL;
            cnt_n     = CW'(RESTART_CYC - 1);
            upd       = 1'b1;
            upd_hit   = live_dt;
          end else begin
            issue   = 1'b1;
            upd     = 1'b1;
            upd_hit = live_route.dtcm;
          end
        end
      end
      default: begin
        if (cnt_q == '0) begin
          req_ready = 1'b1;
          issue     = 1'b1;
          upd       = 1'b1;
          upd_hit   = hold_route_q.dtcm;
          st_n      = S_IDLE;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      cnt_q        <= '0;
      hold_route_q <= '0;
      hold_wr_q    <= 1'b0;
      hold_addr_q  <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (cap) begin
        hold_route_q <= live_route;
        hold_wr_q    <= req_write;
        hold_addr_q  <= req_addr;
      end
    end
  end

endmodule

// File: rtl/dside_router.sv
module dside_router
  import dsr_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int SW          = 6,
  parameter int RESTART_CYC = 2,
  parameter int ITCM_DLY    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_cacheable,
  input  logic          req_wthru,
  input  logic          cache_en,
  input  logic          dtcm_on,
  input  logic [AW-1:0] dtcm_base,
  input  logic [SW-1:0] dtcm_szlog,
  input  logic          itcm_on,
  input  logic [AW-1:0] itcm_base,
  input  logic [SW-1:0] itcm_szlog,
  input  logic          dc_hit,
  output logic [AW-1:0] mem_addr,
  output logic          dtcm_cs,
  output logic          dtcm_we,
  output logic          itcm_cs,
  output logic          itcm_we,
  output logic          dc_rd,
  output logic          dc_wr,
  output logic          fill_req,
  output logic          l2_rd,
  output logic          l2_wr,
  input  logic [DW-1:0] dtcm_rdata,
  input  logic [DW-1:0] itcm_rdata,
  input  logic [DW-1:0] dc_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  localparam int NWIN  = 2;
  localparam int W_DT  = 0;
  localparam int W_IT  = 1;

  logic [NWIN-1:0] win_on;
  logic [AW-1:0]   win_base [NWIN];
  logic [SW-1:0]   win_sz   [NWIN];
  logic [NWIN-1:0] win_hit;

  assign win_on[W_DT]   = dtcm_on;
  assign win_on[W_IT]   = itcm_on;
  assign win_base[W_DT] = dtcm_base;
  assign win_base[W_IT] = itcm_base;
  assign win_sz[W_DT]   = dtcm_szlog;
  assign win_sz[W_IT]   = itcm_szlog;

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      dsr_range #(.AW(AW), .SW(SW)) u_rng (
        .en   (win_on[g]),
        .base (win_base[g]),
        .szlog(win_sz[g]),
        .addr (req_addr),
        .hit  (win_hit[g])
      );
    end
  endgenerate

  route_t live_route;

  dsr_decode u_dec (
    .it_hit   (win_hit[W_IT]),
    .dt_hit   (win_hit[W_DT]),
    .dc_hit   (dc_hit),
    .wr       (req_write),
    .cacheable(req_cacheable),
    .wthru    (req_wthru),
    .cache_en (cache_en),
    .route    (live_route)
  );

  logic pred, upd, upd_hit, issue, iss_write, spec_dtcm;
  route_t iss_route;
  logic [AW-1:0] iss_addr;

  dsr_predict u_pred (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (upd),
    .upd_hit(upd_hit),
    .pred   (pred)
  );

  dsr_seq #(.AW(AW), .RESTART_CYC(RESTART_CYC), .ITCM_DLY(ITCM_DLY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .live_route(live_route),
    .live_it   (win_hit[W_IT]),
    .live_dt   (win_hit[W_DT]),
    .pred      (pred),
    .req_ready (req_ready),
    .issue     (issue),
    .iss_route (iss_route),
    .iss_write (iss_write),
    .iss_addr  (iss_addr),
    .upd       (upd),
    .upd_hit   (upd_hit),
    .spec_dtcm (spec_dtcm)
  );

  route_t drv;

  always_comb begin
    drv      = issue ? iss_route : '0;
    mem_addr = iss_addr;
    dtcm_cs  = drv.dtcm | spec_dtcm;
    dtcm_we  = drv.dtcm & iss_write;
    itcm_cs  = drv.itcm;
    itcm_we  = drv.itcm & iss_write;
    dc_rd    = drv.c_rd;
    dc_wr    = drv.c_wr;
    fill_req = drv.fill;
    l2_rd    = drv.l2_rd;
    l2_wr    = drv.l2_wr;
  end

  // Read response: one registered pulse, source remembered for the data mux
  logic     rsp_q, rsp_n;
  rsp_src_e src_q, src_n;

  always_comb begin
    rsp_n = issue && !iss_write && (drv.dtcm || drv.itcm || drv.c_rd);
    src_n = src_q;
    if (rsp_n) begin
      if (drv.dtcm)      src_n = SRC_DTCM;
      else if (drv.itcm) src_n = SRC_ITCM;
      else               src_n = SRC_DC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0;
      src_q <= SRC_DTCM;
    end else begin
      rsp_q <= rsp_n;
      src_q <= src_n;
    end
  end

  always_comb begin
    case (src_q)
      SRC_DTCM: rsp_data = dtcm_rdata;
      SRC_ITCM: rsp_data = itcm_rdata;
      default:  rsp_data = dc_rdata;
    endcase
  end

  assign rsp_valid = rsp_q;

endmodule

// File: rtl/dside_router_chk.sv
module dside_router_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic req_cacheable,
  input logic req_wthru,
  input logic cache_en,
  input logic dtcm_we,
  input logic itcm_cs,
  input logic itcm_we,
  input logic dc_rd,
  input logic dc_wr,
  input logic fill_req,
  input logic l2_rd,
  input logic l2_wr,
  input logic rsp_valid
);

  logic [3:0] stall_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_c <= '0;
    else if (req_valid && !req_ready) stall_c <= (stall_c == 4'hF) ? stall_c : stall_c + 4'd1;
    else stall_c <= '0;
  end

  assert_itcm_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    itcm_cs |-> !(dtcm_we || dc_rd || dc_wr || fill_req || l2_rd || l2_wr));

  assert_dtcm_no_cache_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dtcm_we |-> !(dc_wr || dc_rd));

  assert_tcm_no_l2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dtcm_we || itcm_we) |-> !l2_wr);

  assert_fill_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> (!req_write && req_cacheable && cache_en));

  assert_wt_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dc_wr |-> (l2_wr == req_wthru));

  assert_itcm_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    itcm_cs |-> (stall_c >= 4'd3));

  assert_rsp_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_strobe_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (itcm_cs || dc_rd || dc_wr || fill_req || l2_rd || l2_wr || dtcm_we) |-> (req_valid && req_ready));

endmodule

bind dside_router dside_router_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_cacheable(req_cacheable),
  .req_wthru    (req_wthru),
  .cache_en     (cache_en),
  .dtcm_we      (dtcm_we),
  .itcm_cs      (itcm_cs),
  .itcm_we      (itcm_we),
  .dc_rd        (dc_rd),
  .dc_wr        (dc_wr),
  .fill_req     (fill_req),
  .l2_rd        (l2_rd),
  .l2_wr        (l2_wr),
  .rsp_valid    (rsp_valid)
);

// File: tb/sim_dside_router.sv
module sim_dside_router;

  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int SW  = 6;
  localparam int RST = 2;
  localparam int ITD = 3;

  localparam int B_DT = 0, B_IT = 1, B_CR = 2, B_CW = 3, B_FL = 4, B_LR = 5, B_LW = 6;

  localparam logic [DW-1:0] D_DT = 32'hA5A5_0001;
  localparam logic [DW-1:0] D_IT = 32'h5A5A_0002;
  localparam logic [DW-1:0] D_DC = 32'hC3C3_0003;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, req_cacheable, req_wthru, cache_en;
  logic [AW-1:0] req_addr;
  logic dtcm_on, itcm_on, dc_hit;
  logic [AW-1:0] dtcm_base, itcm_base, mem_addr;
  logic [SW-1:0] dtcm_szlog, itcm_szlog;
  logic dtcm_cs, dtcm_we, itcm_cs, itcm_we, dc_rd, dc_wr, fill_req, l2_rd, l2_wr;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [DW-1:0] dtcm_rdata = D_DT;
  logic [DW-1:0] itcm_rdata = D_IT;
  logic [DW-1:0] dc_rdata   = D_DC;

  always #5 clk = ~clk;

  dside_router #(.AW(AW), .DW(DW), .SW(SW), .RESTART_CYC(RST), .ITCM_DLY(ITD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_cacheable(req_cacheable),
    .req_wthru(req_wthru), .cache_en(cache_en), .dtcm_on(dtcm_on),
    .dtcm_base(dtcm_base), .dtcm_szlog(dtcm_szlog), .itcm_on(itcm_on),
    .itcm_base(itcm_base), .itcm_szlog(itcm_szlog), .dc_hit(dc_hit),
    .mem_addr(mem_addr), .dtcm_cs(dtcm_cs), .dtcm_we(dtcm_we), .itcm_cs(itcm_cs),
    .itcm_we(itcm_we), .dc_rd(dc_rd), .dc_wr(dc_wr), .fill_req(fill_req),
    .l2_rd(l2_rd), .l2_wr(l2_wr), .dtcm_rdata(dtcm_rdata), .itcm_rdata(itcm_rdata),
    .dc_rdata(dc_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string scen  = "R6 reset";

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s) %s act=%h exp=%h t=%0t", rq, scen, what, act, exp, $time);
    end
  endtask

  function automatic logic in_win(input logic [31:0] a, input logic on, input logic [31:0] b, input logic [SW-1:0] lg);
    longint lim;
    lim = longint'(b) + (longint'(1) << lg);
    return on && (a >= b) && (longint'(a) < lim);
  endfunction

  function automatic logic [6:0] route_of(input logic ith, input logic dth, input logic dch,
                                          input logic wr, input logic cb, input logic wt,
                                          input logic ce, output string tag);
    logic [6:0] r;
    r = '0;
    if (ith)       begin r[B_IT] = 1; tag = "R1"; end
    else if (dth)  begin r[B_DT] = 1; tag = "R2"; end
    else if (dch)  begin tag = "R5"; if (wr) begin r[B_CW] = 1; r[B_LW] = wt; end else r[B_CR] = 1; end
    else begin
      tag = "R4";
      if (wr) r[B_LW] = 1;
      else if (cb && ce) r[B_FL] = 1;
      else r[B_LR] = 1;
    end
    return r;
  endfunction

  // Reference model state
  int         m_left = 0;
  logic       m_pred = 0;
  logic [6:0] m_held = '0;
  logic       m_held_wr = 0;
  string      m_held_tag = "";
  string      m_stall_tag = "";
  logic       m_rsp = 0;
  logic [DW-1:0] m_rsp_data = '0;

  always @(negedge clk) begin
    logic [6:0] er, r;
    logic ith, dth, iss, iwr, spec, exp_ready;
    string rtag, stag, ltag;
    if (rst_n && !done) begin
      er = '0; iss = 0; iwr = 0; spec = 0; exp_ready = 1; rtag = "R11"; stag = "R11";
      if (m_left == 0) begin
        if (req_valid) begin
          ith  = in_win(req_addr, itcm_on, itcm_base, itcm_szlog);
          dth  = in_win(req_addr, dtcm_on, dtcm_base, dtcm_szlog);
          r    = route_of(ith, dth, dc_hit, req_write, req_cacheable, req_wthru, cache_en, ltag);
          spec = m_pred;
          if (ith) begin
            m_left = ITD; m_held = r; m_held_wr = req_write; m_held_tag = ltag;
            m_stall_tag = "R8"; exp_ready = 0; stag = "R8";
          end else if (dth != m_pred) begin
            m_left = RST; m_held = r; m_held_wr = req_write; m_held_tag = ltag;
            m_stall_tag = "R7"; exp_ready = 0; stag = "R7"; m_pred = dth;
          end else begin
            iss = 1; er = r; iwr = req_write; rtag = ltag; stag = "R7";
          end
        end
      end else begin
        m_left--;
        stag = m_stall_tag;
        if (m_left == 0) begin
          iss = 1; er = m_held; iwr = m_held_wr; rtag = m_held_tag; exp_ready = 1;
        end else exp_ready = 0;
      end

      chk(stag, "req_ready", 32'(req_ready), 32'(exp_ready));
      chk("R6", "dtcm_cs", 32'(dtcm_cs), 32'(er[B_DT] | spec));
      chk(rtag, "dtcm_we", 32'(dtcm_we), 32'(er[B_DT] & iwr));
      chk(rtag, "itcm_cs", 32'(itcm_cs), 32'(er[B_IT]));
      chk(rtag, "itcm_we", 32'(itcm_we), 32'(er[B_IT] & iwr));
      chk(rtag, "dc_rd",   32'(dc_rd),   32'(er[B_CR]));
      chk(rtag, "dc_wr",   32'(dc_wr),   32'(er[B_CW]));
      chk(rtag, "fill_req",32'(fill_req),32'(er[B_FL]));
      chk(rtag, "l2_rd",   32'(l2_rd),   32'(er[B_LR]));
      chk(rtag, "l2_wr",   32'(l2_wr),   32'(er[B_LW]));
      chk("R10", "rsp_valid", 32'(rsp_valid), 32'(m_rsp));
      if (m_rsp) chk("R10", "rsp_data", rsp_data, m_rsp_data);

      if (iss) m_pred = er[B_DT];
      m_rsp = iss && !iwr && (er[B_DT] || er[B_IT] || er[B_CR]);
      m_rsp_data = er[B_DT] ? D_DT : (er[B_IT] ? D_IT : D_DC);
    end
  end

  task automatic acc(input logic [31:0] a, input logic wr, input logic cb, input logic wt, input logic dch);
    req_addr = a; req_write = wr; req_cacheable = cb; req_wthru = wt; dc_hit = dch;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; dc_hit = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  localparam logic [31:0] DB = 32'h1000_0000;
  localparam logic [31:0] IB = 32'h0000_0000;

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_write = 0; req_cacheable = 0;
    req_wthru = 0; cache_en = 1; dc_hit = 0;
    dtcm_on = 1; dtcm_base = DB; dtcm_szlog = 6'd12;
    itcm_on = 1; itcm_base = IB; itcm_szlog = 6'd14;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2);

    scen = "R6 R7 predictor";
    acc(DB + 32'h10, 0, 1, 0, 0);     // mispredict after reset
    acc(DB + 32'h14, 0, 1, 0, 0);     // predicted
    acc(DB + 32'h18, 1, 1, 1, 0);     // predicted write
    acc(32'h2000_0040, 0, 1, 0, 1);   // predicted hit, goes to cache: restart
    acc(32'h2000_0044, 0, 1, 0, 1);

    scen = "R5 cache hit";
    acc(32'h2000_0048, 1, 1, 1, 1);
    acc(32'h2000_004C, 1, 1, 0, 1);
    acc(32'h2000_0050, 0, 0, 0, 1);

    scen = "R4 all miss";
    acc(32'h3000_0000, 0, 1, 0, 0);
    cache_en = 0;
    acc(32'h3000_0004, 0, 1, 0, 0);
    cache_en = 1;
    acc(32'h3000_0008, 0, 0, 0, 0);
    acc(32'h3000_000C, 1, 1, 1, 0);
    acc(32'h3000_0010, 1, 0, 0, 0);

    scen = "R1 R8 itcm";
    acc(IB + 32'h100, 0, 1, 0, 1);
    acc(IB + 32'h104, 1, 1, 1, 1);
    for (int k = 0; k < 4; k++) acc(IB + 32'h200 + 32'(4*k), 0, 1, 0, 0);
    for (int k = 0; k < 3; k++) acc(IB + 32'h300 + 32'(4*k), 1, 0, 1, 0);

    scen = "R2 R3 dtcm over cache";
    acc(DB + 32'h40, 0, 1, 0, 1);
    acc(DB + 32'h44, 1, 1, 1, 1);
    acc(DB + 32'h48, 0, 1, 1, 1);
    for (int k = 0; k < 4; k++) acc(DB + 32'(4*k), 0, 1, 0, 0);

    scen = "R9 window edges";
    acc(DB - 32'h1, 0, 1, 0, 0);
    acc(DB, 0, 1, 0, 0);
    acc(DB + 32'hFFF, 1, 1, 1, 0);
    acc(DB + 32'h1000, 1, 1, 1, 0);
    acc(IB + 32'h3FFF, 0, 1, 0, 0);
    acc(IB + 32'h4000, 0, 1, 0, 0);
    dtcm_on = 0;
    acc(DB + 32'h8, 0, 1, 0, 0);
    acc(DB + 32'hC, 1, 1, 1, 1);
    dtcm_on = 1;
    itcm_on = 0;
    acc(IB + 32'h10, 0, 0, 0, 0);
    itcm_on = 1;

    scen = "R1 overlap";
    itcm_base = 32'h0FFF_F000; itcm_szlog = 6'd13;
    acc(DB + 32'h800, 0, 1, 0, 1);
    acc(DB + 32'h804, 1, 1, 1, 1);
    acc(DB + 32'h1000, 0, 1, 0, 0);
    itcm_base = IB; itcm_szlog = 6'd14;

    scen = "R11 idle";
    idle(4);
    acc(DB + 32'h20, 0, 0, 0, 0);
    idle(2);
    acc(32'h4000_0000, 0, 0, 0, 0);
    idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog (%s) act=hang exp=finish", scen);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule